// File: doc/BRIEF.md
# Boolean Nested Logic Trigger

This block turns four already-sliced logic channels into a trigger decision. Two programmable Boolean conditions, A and B, are each held as a 16-entry truth table over the 4-bit channel vector. A mode field picks whether the trigger follows A alone, B alone, or a nested sequence. In the nested sequence an A event arms the unit, and a later B event fires the trigger. A fourth mode code disables triggering.

A condition can be sampled only on rising edges of an external qualifying clock. A minimum-duration filter, counted in system clock cycles, rejects condition matches that are too short. An asynchronous inhibit input blocks any trigger and drops the armed state while it is active.

The block has three outputs. The first is a one-cycle trigger pulse. The second is an interval gate that is high while the unit is armed. The third is a front output that carries one of the first two, chosen by a select bit. The channel, qualifying clock and inhibit inputs each pass through a two-flop synchronizer.

Top module: `logic_seq_trigger`

## Requirements
- R1: Condition X (A or B) is true when bit `chan_in` of its table is 1. The table index is the 4-bit channel vector, with `chan_in[0]` as the least significant index bit.
- R2: With `mode` = 2'b00 (A only), each rising edge of the filtered A condition gives one trigger pulse. The pulse is due 4 + max(`min_len`,1) cycles after the channel change, and B has no effect.
- R3: With `mode` = 2'b01 (B only), each rising edge of the filtered B condition gives one trigger pulse, with the same latency as R2.
- R4: With `mode` = 2'b10 (nested), an A event arms the unit and a following B event fires the trigger. A B event while unarmed does nothing. After firing, the unit returns to unarmed.
- R5: `gate_out` rises in the cycle the unit arms and falls in the same cycle the nested trigger pulse appears.
- R6: A condition must be true for at least `min_len` consecutive sampled cycles to produce an event; a shorter match yields nothing. A `min_len` of 0 behaves as 1.
- R7: When `qual_en` is 1, a condition is sampled only on rising edges of `ext_clk`. Channel changes between those edges have no effect.
- R8: While `inhibit_in` is high, no trigger is produced. The armed state is cleared 3 cycles after `inhibit_in` rises.
- R9: `front_out` equals `gate_out` when `front_sel` is 1 and equals `trig_pulse` when `front_sel` is 0.
- R10: The trigger is a single-cycle pulse. A condition held true gives only one pulse.
- R11: With `mode` = 2'b11, no trigger is produced and the unit never arms.
- R12: After reset, `trig_pulse`, `gate_out` and `front_out` are low.
- R13: In nested mode, if A and B events occur in the same cycle while unarmed, the unit only arms. A later event pair fires the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| chan_in | input | 4 | Sliced logic channels, asynchronous |
| ext_clk | input | 1 | External qualifying clock, asynchronous |
| inhibit_in | input | 1 | Trigger inhibit, active high, asynchronous |
| tbl_a | input | 16 | Truth table of condition A |
| tbl_b | input | 16 | Truth table of condition B |
| mode | input | 2 | 00 A only, 01 B only, 10 nested, 11 off |
| qual_en | input | 1 | Sample conditions only on external clock rising edges |
| min_len | input | 7 | Minimum match length in clock cycles |
| front_sel | input | 1 | 0: front carries trigger, 1: front carries gate |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| gate_out | output | 1 | Armed interval gate |
| front_out | output | 1 | Selected front output |

## Verification
A channel change reaches `trig_pulse` 4 + max(`min_len`,1) cycles later. That delay is two synchronizer stages, the sample register, the filter and the sequencer register. The arming of `gate_out` follows the same count. A rising `inhibit_in` clears `gate_out` after 3 cycles, and a qualifying clock edge behaves like a channel change. The bench drives every input on a falling edge. It then counts falling edges and records the exact index at which each output first changes, and compares that index with the count stated in the requirement.

// File: rtl/lstrig_pkg.sv
package lstrig_pkg;
    typedef enum logic [1:0] {
        MODE_A_ONLY = 2'b00,
        MODE_B_ONLY = 2'b01,
        MODE_NESTED = 2'b10,
        MODE_OFF    = 2'b11
    } trig_mode_e;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/cond_filter.sv
module cond_filter #(
    parameter int NUM_CH = 4,
    parameter int LEN_W  = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    chan_s,
    input  logic [2**NUM_CH-1:0] cond_tbl,
    input  logic                 take,
    input  logic [LEN_W-1:0]     min_len,
    output logic                 evt
);
    localparam logic [LEN_W-1:0] RUN_MAX = {LEN_W{1'b1}};

    typedef struct packed {
        logic             samp;
        logic [LEN_W-1:0] run;
        logic             filt;
        logic             filt_prev;
    } flt_t;

    flt_t flt_d, flt_q;
    logic [LEN_W:0] run_p1;

    always_comb begin
        flt_d = flt_q;
        run_p1 = {1'b0, flt_q.run} + (LEN_W+1)'(1);
        if (take) begin
            flt_d.samp = cond_tbl[chan_s];
        end
        flt_d.filt_prev = flt_q.filt;
        if (flt_q.samp) begin
            flt_d.run  = (flt_q.run == RUN_MAX) ? flt_q.run : run_p1[LEN_W-1:0];
            flt_d.filt = (run_p1 >= {1'b0, min_len});
        end else begin
            flt_d.run  = '0;
            flt_d.filt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '0;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign evt = flt_q.filt & ~flt_q.filt_prev;

    logic samp_q, filt_q;
    assign samp_q = flt_q.samp;
    assign filt_q = flt_q.filt;

    AST_FILT_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        filt_q |-> $past(samp_q)); // R6
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt); // R10
endmodule

// File: rtl/seq_core.sv
module seq_core
    import lstrig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_a,
    input  logic       evt_b,
    input  logic       inhibit,
    input  logic [1:0] mode,
    output logic       trig_o,
    output logic       armed_o
);
    typedef struct packed {
        logic armed;
        logic fire;
    } seq_t;

    seq_t seq_d, seq_q;
    trig_mode_e mode_e;

    assign mode_e = trig_mode_e'(mode);

    always_comb begin
        seq_d = seq_q;
        seq_d.fire = 1'b0;
        if (inhibit) begin
            seq_d.armed = 1'b0;
        end else begin
            case (mode_e)
                MODE_A_ONLY: begin
                    seq_d.armed = 1'b0;
                    seq_d.fire  = evt_a;
                end
                MODE_B_ONLY: begin
                    seq_d.armed = 1'b0;
                    seq_d.fire  = evt_b;
                end
                MODE_NESTED: begin
                    if (seq_q.armed) begin
                        if (evt_b) begin
                            seq_d.fire  = 1'b1;
                            seq_d.armed = 1'b0;
                        end
                    end else if (evt_a) begin
                        seq_d.armed = 1'b1;
                    end
                end
                default: begin
                    seq_d.armed = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign trig_o  = seq_q.fire;
    assign armed_o = seq_q.armed;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o); // R10
    AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> (!trig_o && !armed_o)); // R8
    AST_NEST_ARMED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && $past(mode) == MODE_NESTED) |-> $past(armed_o)); // R4
    AST_ARM_ONLY_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o |-> ($past(mode) == MODE_NESTED)); // R5
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == MODE_OFF) |-> (!trig_o && !armed_o)); // R11
endmodule

// File: rtl/logic_seq_trigger.sv
module logic_seq_trigger
    import lstrig_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int LEN_W  = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    chan_in,
    input  logic                 ext_clk,
    input  logic                 inhibit_in,
    input  logic [2**NUM_CH-1:0] tbl_a,
    input  logic [2**NUM_CH-1:0] tbl_b,
    input  logic [1:0]           mode,
    input  logic                 qual_en,
    input  logic [LEN_W-1:0]     min_len,
    input  logic                 front_sel,
    output logic                 trig_pulse,
    output logic                 gate_out,
    output logic                 front_out
);
    localparam int TBL_W = 2**NUM_CH;
    localparam int N_COND = 2;

    logic [NUM_CH-1:0] chan_s;
    logic [1:0]        ctl_s;
    logic              ext_s, inh_s;
    logic              ext_prev_d, ext_prev_q;
    logic              take;
    logic [N_COND-1:0][TBL_W-1:0] tbl_sel;
    logic [N_COND-1:0] evts;
    logic              trig_w, armed_w;

    bit_sync #(.W(NUM_CH)) u_sync_chan (
        .clk(clk), .rst_n(rst_n), .async_in(chan_in), .sync_out(chan_s)
    );

    bit_sync #(.W(2)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n), .async_in({inhibit_in, ext_clk}), .sync_out(ctl_s)
    );

    assign ext_s = ctl_s[0];
    assign inh_s = ctl_s[1];

    always_comb begin
        ext_prev_d = ext_s;
        take = ~qual_en | (ext_s & ~ext_prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_prev_q <= 1'b0;
        end else begin
            ext_prev_q <= ext_prev_d;
        end
    end

    assign tbl_sel = {tbl_b, tbl_a};

    for (genvar g = 0; g < N_COND; g++) begin : g_cond
        cond_filter #(.NUM_CH(NUM_CH), .LEN_W(LEN_W)) u_filt (
            .clk(clk), .rst_n(rst_n), .chan_s(chan_s), .cond_tbl(tbl_sel[g]),
            .take(take), .min_len(min_len), .evt(evts[g])
        );
    end

    seq_core u_core (
        .clk(clk), .rst_n(rst_n), .evt_a(evts[0]), .evt_b(evts[1]),
        .inhibit(inh_s), .mode(mode), .trig_o(trig_w), .armed_o(armed_w)
    );

    assign trig_pulse = trig_w;
    assign gate_out   = armed_w;
    assign front_out  = front_sel ? armed_w : trig_w;

    AST_QUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_en && !take) |=> !trig_pulse || $past(trig_pulse) == 1'b0); // R7
    AST_FRONT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        front_out |-> (trig_pulse || gate_out)); // R9
endmodule

// File: tb/logic_seq_trigger_bench.sv
module logic_seq_trigger_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] chan_in = '0;
    logic       ext_clk = 1'b0;
    logic       inhibit_in = 1'b0;
    logic [15:0] tbl_a = '0, tbl_b = '0;
    logic [1:0] mode = 2'b00;
    logic       qual_en = 1'b0;
    logic [6:0] min_len = '0;
    logic       front_sel = 1'b0;
    logic       trig_pulse, gate_out, front_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    logic_seq_trigger u_logic_seq_trigger (
        .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .ext_clk(ext_clk),
        .inhibit_in(inhibit_in), .tbl_a(tbl_a), .tbl_b(tbl_b), .mode(mode),
        .qual_en(qual_en), .min_len(min_len), .front_sel(front_sel),
        .trig_pulse(trig_pulse), .gate_out(gate_out), .front_out(front_out)
    );

    typedef struct packed {
        logic [1:0]  vmode;
        logic [15:0] ta;
        logic [15:0] tb;
        logic [6:0]  len;
        logic [3:0]  ch;
        logic [7:0]  hold;
        logic [1:0]  cnt;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 16'h0008, 16'h0000, 7'd0, 4'h3, 8'd3,  2'd1}, // R1 R2 match
        '{2'b00, 16'h0008, 16'h0000, 7'd0, 4'h5, 8'd3,  2'd0}, // R1 no match
        '{2'b01, 16'h0000, 16'h8000, 7'd2, 4'hF, 8'd2,  2'd1}, // R3
        '{2'b01, 16'h0000, 16'h8000, 7'd5, 4'hF, 8'd4,  2'd0}, // R6 short
        '{2'b01, 16'h0000, 16'h8000, 7'd5, 4'hF, 8'd5,  2'd1}, // R6 exact
        '{2'b00, 16'h0010, 16'h0000, 7'd0, 4'h4, 8'd1,  2'd1}, // R6 zero length
        '{2'b00, 16'hFFFE, 16'h0000, 7'd0, 4'h9, 8'd20, 2'd1}, // R10 held
        '{2'b11, 16'hFFFE, 16'hFFFE, 7'd0, 4'h9, 8'd5,  2'd0}, // R11 off
        '{2'b00, 16'h0000, 16'hFFFE, 7'd0, 4'h9, 8'd5,  2'd0}  // R2 B ignored
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        chan_in = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic watch(input logic [3:0] ch, input int hold, input int n,
                         output int tcnt, output int tfirst, output int ghi,
                         output int glo, output int ffirst);
        chan_in = ch;
        tcnt = 0; tfirst = -1; ghi = -1; glo = -1; ffirst = -1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (hold != 0 && i == hold) chan_in = '0;
            if (trig_pulse) begin
                tcnt++;
                if (tfirst < 0) tfirst = i;
            end
            if (gate_out && ghi < 0) ghi = i;
            if (!gate_out && glo < 0) glo = i;
            if (front_out && ffirst < 0) ffirst = i;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int tc, tf, gh, gl, ff, lp;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(trig_pulse == 1'b0, "R12 trig", trig_pulse, 0);
        check(gate_out == 1'b0, "R12 gate", gate_out, 0);
        check(front_out == 1'b0, "R12 front", front_out, 0);

        for (int v = 0; v < NV; v++) begin
            mode = VECS[v].vmode; tbl_a = VECS[v].ta; tbl_b = VECS[v].tb;
            min_len = VECS[v].len;
            idle(10);
            lp = (VECS[v].len == 0) ? 1 : int'(VECS[v].len);
            watch(VECS[v].ch, int'(VECS[v].hold), int'(VECS[v].hold) + lp + 8, tc, tf, gh, gl, ff);
            check(tc == int'(VECS[v].cnt), $sformatf("R2/R3/R6 vec%0d count", v), tc, int'(VECS[v].cnt));
            if (VECS[v].cnt != 0)
                check(tf == 4 + lp, $sformatf("R2/R3 vec%0d latency", v), tf, 4 + lp);
            check(gh < 0, $sformatf("R11 vec%0d no arm", v), gh, -1);
        end

        // R4 R5 R9 nested sequence
        mode = 2'b10; tbl_a = 16'h0002; tbl_b = 16'h0004; min_len = 0; front_sel = 1'b1;
        idle(10);
        watch(4'h1, 2, 12, tc, tf, gh, gl, ff);
        check(gh == 5, "R5 gate rise", gh, 5);
        check(tc == 0, "R4 A alone no trigger", tc, 0);
        check(ff == 5, "R9 front follows gate", ff, 5);
        front_sel = 1'b0;
        watch(4'h2, 2, 12, tc, tf, gh, gl, ff);
        check(tf == 5, "R4 B fires", tf, 5);
        check(tc == 1, "R4 one trigger", tc, 1);
        check(gl == 5, "R5 gate fall", gl, 5);
        check(ff == 5, "R9 front follows trigger", ff, 5);
        watch(4'h2, 2, 12, tc, tf, gh, gl, ff);
        check(tc == 0, "R4 unarmed B ignored", tc, 0);
        check(gh < 0, "R4 stays unarmed", gh, -1);

        // R8 inhibit
        watch(4'h1, 2, 12, tc, tf, gh, gl, ff);
        check(gh == 5, "R8 arm before inhibit", gh, 5);
        inhibit_in = 1'b1;
        watch(4'h0, 0, 6, tc, tf, gh, gl, ff);
        check(gl == 3, "R8 arm cleared", gl, 3);
        watch(4'h2, 2, 12, tc, tf, gh, gl, ff);
        check(tc == 0, "R8 no trigger while inhibited", tc, 0);
        inhibit_in = 1'b0;
        idle(6);
        watch(4'h2, 2, 12, tc, tf, gh, gl, ff);
        check(tc == 0, "R8 arm lost after inhibit", tc, 0);
        mode = 2'b00; inhibit_in = 1'b1;
        idle(6);
        watch(4'h1, 2, 12, tc, tf, gh, gl, ff);
        check(tc == 0, "R8 A-only inhibited", tc, 0);
        inhibit_in = 1'b0;
        idle(6);
        watch(4'h1, 2, 12, tc, tf, gh, gl, ff);
        check(tc == 1, "R8 A-only after release", tc, 1);

        // R13 simultaneous A and B
        mode = 2'b10; tbl_a = 16'h0020; tbl_b = 16'h0020;
        idle(10);
        watch(4'h5, 2, 12, tc, tf, gh, gl, ff);
        check(gh == 5, "R13 arms", gh, 5);
        check(tc == 0, "R13 no trigger on first pair", tc, 0);
        watch(4'h5, 2, 12, tc, tf, gh, gl, ff);
        check(tf == 5, "R13 second pair fires", tf, 5);

        // R7 qualification
        mode = 2'b00; tbl_a = 16'h0008; qual_en = 1'b1; ext_clk = 1'b0;
        idle(10);
        watch(4'h3, 0, 15, tc, tf, gh, gl, ff);
        check(tc == 0, "R7 no edge no trigger", tc, 0);
        ext_clk = 1'b1;
        watch(4'h3, 0, 12, tc, tf, gh, gl, ff);
        check(tf == 5, "R7 edge samples match", tf, 5);
        ext_clk = 1'b0;
        idle(10);
        watch(4'h3, 0, 12, tc, tf, gh, gl, ff);
        check(tc == 0, "R7 change between edges ignored", tc, 0);
        chan_in = '0;
        ext_clk = 1'b1;
        idle(8);
        ext_clk = 1'b0;
        qual_en = 1'b0;
        idle(8);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule